// File: doc/BRIEF.md
# ADC Conversion Timing Controller

This block produces the digital timing for one successive-approximation conversion. It takes a 5-bit mode field made of a 3-bit clock-select code and a 2-bit supply-range code. From the clock-select code it derives a conversion-clock enable strobe from the system clock. It then counts a fixed number of those conversion-clock periods per conversion: 20 periods in the two normal ranges and 25 in the low-supply range. The comparator, the bit-decision logic and the result storage live elsewhere and advance on the strobe.

In the two boosted ranges, a start is taken only when the input-boost enable is high and has stayed high for a stabilization time. That time is counted in system clocks, rounded up from a frequency parameter. The prohibited range code raises an illegal-setting flag and blocks starts. Any start that is not taken sets a sticky rejected-start flag, which is cleared through a dedicated input.

Top module: `adc_conv_timer`

## Requirements
- R1: Clock select `mode_i[4:2]` picks the divisor 0→12, 1→8, 2→6, 3→5, 4→4, 5→3, 6→2, 7→1. While busy, `conv_clk_en_o` is high for one cycle in every divisor cycles. Its first pulse falls in the divisor-th busy cycle.
- R2: With range code `mode_i[1:0]` equal to 00 or 01, a conversion lasts 20 conversion-clock periods, so `busy_o` is high for 20×divisor cycles.
- R3: With range code 10, a conversion lasts 25 periods, so `busy_o` is high for 25×divisor cycles.
- R4: Range code 11 drives `illegal_o` high. A start under it does not raise `busy_o`.
- R5: Range code 00 needs no boost. With codes 01 or 10, a start while `boost_en_i` is low is not taken.
- R6: A start is taken in a boosted range only once `boost_en_i` has been high for ceil(SYS_CLK_HZ×STAB_NS/1e9) rising edges. A start sampled on the edge before that count is complete is not taken.
- R7: Any low cycle on `boost_en_i` restarts the stabilization wait from zero.
- R8: The mode field is captured when a start is taken. Later changes to `mode_i` do not alter the running conversion.
- R9: `busy_o` rises on the edge that takes a start. `eoc_o` is a one-cycle pulse in the last busy cycle, and `busy_o` falls on the following edge.
- R10: A start that is not taken, including one during busy, sets `rej_o`. `rej_o` holds until `rej_clr_i` is high, and a new rejection in the same cycle as a clear wins.
- R11: With divisor 1, `conv_clk_en_o` is high in every busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | [4:2] clock select, [1:0] supply range |
| boost_en_i | input | 1 | Input-boost circuit enabled |
| start_i | input | 1 | Start request, sampled each cycle |
| rej_clr_i | input | 1 | Clears the rejected-start flag |
| conv_clk_en_o | output | 1 | Conversion-clock enable strobe |
| busy_o | output | 1 | Conversion running |
| eoc_o | output | 1 | End-of-conversion pulse |
| illegal_o | output | 1 | Prohibited range selected |
| rej_o | output | 1 | Sticky rejected-start flag |

## Verification
A corrupted prescaler count shows up at once as a misplaced or missing strobe. A corrupted period counter or captured length shows up as a busy window of the wrong length, visible at the end-of-conversion edge at most 300 cycles later. A stabilization counter that runs early or late shifts by one edge the boundary at which a boosted start is first taken. The bench probes that boundary on both sides. A gating fault appears on the next start request, as busy rising when it should not or the sticky flag staying clear.

// File: rtl/adc_ct_pkg.sv
package adc_ct_pkg;

  localparam int DIV_W = 4;

  typedef enum logic [1:0] {
    RNG_NORM_A = 2'b00,
    RNG_NORM_B = 2'b01,
    RNG_LOWV   = 2'b10,
    RNG_BAD    = 2'b11
  } range_e;

  function automatic logic [DIV_W-1:0] sel_to_div(input logic [2:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      3'd0:    d = 4'd12;
      3'd1:    d = 4'd8;
      3'd2:    d = 4'd6;
      3'd3:    d = 4'd5;
      3'd4:    d = 4'd4;
      3'd5:    d = 4'd3;
      3'd6:    d = 4'd2;
      default: d = 4'd1;
    endcase
    return d;
  endfunction

  function automatic logic range_boosted(input range_e r);
    return (r == RNG_NORM_B) || (r == RNG_LOWV);
  endfunction

endpackage

// File: rtl/adc_ct_stab.sv
module adc_ct_stab #(
  parameter int STAB_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boost_en_i,
  output logic ready_o
);
  localparam int CNT_W = (STAB_CYC < 2) ? 1 : $clog2(STAB_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!boost_en_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/adc_ct_presc.sv
module adc_ct_presc #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = run_i && (cnt_q == (div_i - ONE));

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)  cnt_d = '0;
    else if (run_i) cnt_d = tick ? '0 : (cnt_q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/adc_ct_seq.sv
module adc_ct_seq #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] per_q, per_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             busy_q, busy_d;
  logic             last;

  assign last = busy_q && tick_i && (per_q == (len_q - ONE));

  always_comb begin
    per_d  = per_q;
    len_d  = len_q;
    busy_d = busy_q;
    if (accept_i) begin
      per_d  = '0;
      len_d  = len_i;
      busy_d = 1'b1;
    end else if (last) begin
      busy_d = 1'b0;
      per_d  = '0;
    end else if (busy_q && tick_i) begin
      per_d = per_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      len_q  <= len_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = last;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_ct_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ   = 250_000_000,
  parameter int unsigned STAB_NS      = 10_000,
  parameter int          NORM_PERIODS = 20,
  parameter int          LOWV_PERIODS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mode_i,
  input  logic       boost_en_i,
  input  logic       start_i,
  input  logic       rej_clr_i,
  output logic       conv_clk_en_o,
  output logic       busy_o,
  output logic       eoc_o,
  output logic       illegal_o,
  output logic       rej_o
);
  localparam longint STAB_RAW =
    (longint'(SYS_CLK_HZ) * longint'(STAB_NS) + 64'sd999_999_999) / 64'sd1_000_000_000;
  localparam int STAB_CYC = (STAB_RAW < 1) ? 1 : int'(STAB_RAW);
  localparam int MAX_LEN  = (NORM_PERIODS > LOWV_PERIODS) ? NORM_PERIODS : LOWV_PERIODS;
  localparam int LEN_W    = $clog2(MAX_LEN + 1);

  range_e           rng;
  logic [2:0]       sel;
  logic             stab_ready;
  logic             busy;
  logic             tick;
  logic             last;
  logic             boost_ok;
  logic             accept;
  logic [LEN_W-1:0] len_sel;
  logic [DIV_W-1:0] div_q, div_d;
  logic             rej_q, rej_d;

  assign rng = range_e'(mode_i[1:0]);
  assign sel = mode_i[4:2];

  adc_ct_stab #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk        (clk),
    .rst_n      (rst_n),
    .boost_en_i (boost_en_i),
    .ready_o    (stab_ready)
  );

  assign boost_ok = !range_boosted(rng) || (boost_en_i && stab_ready);
  assign accept   = start_i && !busy && (rng != RNG_BAD) && boost_ok;
  assign len_sel  = (rng == RNG_LOWV) ? LEN_W'(LOWV_PERIODS) : LEN_W'(NORM_PERIODS);

  // captured divisor: held for the whole conversion
  always_comb begin
    div_d = div_q;
    if (accept) div_d = sel_to_div(sel);
  end

  always_comb begin
    rej_d = rej_q;
    if (rej_clr_i)              rej_d = 1'b0;
    if (start_i && !accept)     rej_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      rej_q <= 1'b0;
    end else begin
      div_q <= div_d;
      rej_q <= rej_d;
    end
  end

  adc_ct_presc #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (busy),
    .restart_i (accept),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  adc_ct_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .tick_i   (tick),
    .len_i    (len_sel),
    .busy_o   (busy),
    .last_o   (last)
  );

  assign conv_clk_en_o = tick;
  assign busy_o        = busy;
  assign eoc_o         = last;
  assign illegal_o     = (rng == RNG_BAD);
  assign rej_o         = rej_q;
endmodule

// File: rtl/adc_ct_chk.sv
module adc_ct_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] mode_i,
  input logic       start_i,
  input logic       rej_clr_i,
  input logic       conv_clk_en_o,
  input logic       busy_o,
  input logic       eoc_o,
  input logic       rej_o
);
  // R1
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_clk_en_o |-> busy_o);

  // R9
  eoc_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> busy_o);

  // R9
  eoc_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> (!busy_o && !eoc_o));

  // R4
  busy_from_legal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && ($past(mode_i[1:0]) != 2'b11)));

  // R10
  busy_start_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> rej_o);

  // R10
  rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_o && !rej_clr_i) |=> rej_o);
endmodule

bind adc_conv_timer adc_ct_chk u_chk (.*);

// File: tb/adc_conv_timer_tb_top.sv
module adc_conv_timer_tb_top;
  // 12_345_678 Hz x 10 us = 123.45678 -> rounded up to 124 cycles
  localparam int STAB = 124;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] mode_i;
  logic       boost_en_i, start_i, rej_clr_i;
  logic       conv_clk_en_o, busy_o, eoc_o, illegal_o, rej_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int divs[8] = '{12, 8, 6, 5, 4, 3, 2, 1};

  always #2 clk = ~clk;

  adc_conv_timer #(.SYS_CLK_HZ(12_345_678), .STAB_NS(10_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .boost_en_i(boost_en_i),
    .start_i(start_i), .rej_clr_i(rej_clr_i), .conv_clk_en_o(conv_clk_en_o),
    .busy_o(busy_o), .eoc_o(eoc_o), .illegal_o(illegal_o), .rej_o(rej_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at the negedge right after the accepting edge
  task automatic measure(int exp_div, int exp_len, bit disturb, string req);
    int cyc = 0, ticks = 0, first = 0, eocs = 0, eoc_at = 0;
    while (busy_o && cyc < 400) begin
      cyc++;
      if (conv_clk_en_o) begin ticks++; if (first == 0) first = cyc; end
      if (eoc_o) begin eocs++; eoc_at = cyc; end
      if (disturb && cyc == 5) begin mode_i = 5'b00010; start_i = 1'b1; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    check({req, " busy length"}, cyc, exp_div * exp_len);
    check({req, " strobe count"}, ticks, exp_len);
    check({req, " first strobe R1"}, first, exp_div);
    check({req, " eoc pulses R9"}, eocs, 1);
    check({req, " eoc in last cycle R9"}, eoc_at, cyc);
    if (disturb) check({req, " start while busy sets rej R10"}, rej_o, 1);
  endtask

  task automatic run_conv(logic [2:0] sel, logic [1:0] rng, int exp_len, bit disturb, string req);
    @(negedge clk);
    mode_i  = {sel, rng};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({req, " busy after start R9"}, busy_o, 1);
    measure(divs[sel], exp_len, disturb, req);
  endtask

  task automatic clear_rej();
    @(negedge clk); rej_clr_i = 1'b1;
    @(negedge clk); rej_clr_i = 1'b0;
    check("R10 rej cleared", rej_o, 0);
  endtask

  task automatic try_rejected(logic [4:0] m, string req);
    @(negedge clk); mode_i = m; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check({req, " no busy"}, busy_o, 0);
    check({req, " rej set"}, rej_o, 1);
  endtask

  task automatic t_reset();
    check("R9 reset busy", busy_o, 0);
    check("R9 reset eoc", eoc_o, 0);
    check("R1 reset strobe", conv_clk_en_o, 0);
    check("R10 reset rej", rej_o, 0);
    check("R4 reset illegal", illegal_o, 0);
  endtask

  task automatic t_normal_all_sel();
    for (int s = 0; s < 8; s++)
      run_conv(3'(s), 2'b00, 20, 1'b0, (s == 7) ? "R2 R11 sel7" : "R2 R1 normal");
  endtask

  task automatic t_stab();
    try_rejected(5'b11101, "R5 no boost");
    clear_rej();
    @(negedge clk); boost_en_i = 1'b1;
    repeat (STAB - 1) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    check("R6 start one edge early no busy", busy_o, 0);
    check("R6 start one edge early rej", rej_o, 1);
    @(negedge clk);
    start_i = 1'b0;
    check("R6 start at boundary busy", busy_o, 1);
    measure(1, 20, 1'b0, "R6 R2 boosted");
    clear_rej();
  endtask

  task automatic t_boost_drop();
    @(negedge clk); boost_en_i = 1'b0;
    @(negedge clk); boost_en_i = 1'b1;
    try_rejected(5'b11110, "R7 after drop");
    clear_rej();
    repeat (STAB) @(negedge clk);
    run_conv(3'd7, 2'b10, 25, 1'b0, "R7 R3 R11 low-v div1");
    run_conv(3'd0, 2'b10, 25, 1'b0, "R3 low-v div12");
  endtask

  task automatic t_illegal();
    @(negedge clk); mode_i = 5'b00011;
    @(negedge clk);
    check("R4 illegal flag", illegal_o, 1);
    try_rejected(5'b00011, "R4 prohibited start");
    @(negedge clk); mode_i = 5'b00010;
    @(negedge clk);
    check("R4 legal flag low", illegal_o, 0);
    clear_rej();
  endtask

  task automatic t_latch();
    run_conv(3'd6, 2'b00, 20, 1'b1, "R8 R10 latched mode");
    clear_rej();
  endtask

  task automatic t_set_wins();
    @(negedge clk); mode_i = 5'b00011; start_i = 1'b1; rej_clr_i = 1'b1;
    @(negedge clk); start_i = 1'b0; rej_clr_i = 1'b0;
    check("R10 set wins over clear", rej_o, 1);
    clear_rej();
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 5'b0; boost_en_i = 1'b0; start_i = 1'b0; rej_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_all_sel();
    t_stab();
    t_boost_drop();
    t_illegal();
    t_latch();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule